// File: doc/BRIEF.md
# Two-Layer Coincidence Pixel Array Readout

This block is the digital readout of a pixel matrix in which every pixel sits behind two stacked avalanche detectors, one on the upper tier and one on the lower. Each detector's hit line is turned into a pulse of programmable length by its own one-shot. A pixel counts a particle only when the upper and lower pulses are high in the same clock cycle. A noise event that fires just one layer is therefore thrown away. The pulse length sets the coincidence window and can be chosen among three lengths, 1, 2 or 13 clock cycles by default.

Time is cut into frames by a strobe from the system, so the system sets the integration time. Each pixel holds one hit bit per frame. At a frame boundary all hit bits move into a shadow copy and the live bits clear, so the next frame integrates while the previous one is read one row per cycle. In parallel, each pixel keeps a saturating per-pixel count of the frames in which it was hit. The count can be read at any address and cleared by a command.

A pixel mask is shifted in serially, loaded into a pending copy, and applied only at the next frame boundary. A masked pixel never records a hit.

Top module: `coinc_pixel_array`

## Requirements
- R1: A pixel's hit bit is set only in a cycle in which both its upper and lower pulses are high, and any such cycle in an enabled pixel sets it.
- R2: A rising edge on a hit input starts that layer's pulse on the next cycle. The pulse stays high for 1 cycle when `win_sel` is 0, 2 cycles when it is 1, and 13 cycles when it is 2 or 3. Rising edges that arrive while the pulse is high are ignored. With single-cycle hits on both layers, a pixel records a hit exactly when the two rising edges are less than the pulse length apart.
- R3: Pixel index is row*COLS+column. Bit c of `rd_bits` is column c of the selected row, and `cnt_addr` uses the pixel index.
- R4: A pixel whose enable is 0 never sets its hit bit.
- R5: A pixel stores one bit per frame. Further coincidences in the same frame change neither that bit nor the count increment, which is at most one per frame.
- R6: In the cycle `frame_close` is high, every hit bit is copied to the shadow copy and the live bit restarts from that cycle's coincidence. `rd_bits` shows shadow row `rd_row` one cycle after the address is applied. The shadow copy holds until the next `frame_close`.
- R7: With `cfg_shift` high, `cfg_sdi` shifts into the mask register. After ROWS*COLS shifts, the first bit shifted belongs to the highest pixel index and the last to pixel 0, where 1 means enabled. `cfg_load` copies the mask register to the pending mask. The pending mask becomes active only at the next `frame_close`.
- R8: At each `frame_close`, a pixel's count rises by one if its hit bit was set. The count holds at 2^CNT_W-1 instead of wrapping. `cnt_q` shows the count of pixel `cnt_addr` one cycle later.
- R9: `cnt_clear` zeroes every count and takes priority over an increment in the same cycle.
- R10: After reset, all hit bits, shadow bits, pulses and counts are 0, and all pixels are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| top_hit | input | ROWS*COLS | Upper-layer detector hit, one per pixel |
| bot_hit | input | ROWS*COLS | Lower-layer detector hit, one per pixel |
| win_sel | input | 2 | Pulse length select: 0 short, 1 medium, 2 or 3 long |
| frame_close | input | 1 | Frame boundary strobe |
| cfg_sdi | input | 1 | Serial mask data |
| cfg_shift | input | 1 | Shift enable for the mask register |
| cfg_load | input | 1 | Copy mask register to the pending mask |
| cnt_clear | input | 1 | Zero all per-pixel counts |
| rd_row | input | $clog2(ROWS) | Shadow row to read |
| rd_bits | output | COLS | Registered shadow row |
| cnt_addr | input | $clog2(ROWS*COLS) | Pixel whose count is read |
| cnt_q | output | CNT_W | Registered count of the addressed pixel |

## Verification
For each window length, the main sweep puts single-cycle hits on both layers of one pixel and offsets them by every amount from -14 to +14 cycles. The sweep shows whether the recorded bit turns on exactly when the offset is below the pulse length. It separates an inclusive from an exclusive window boundary, and a delayed from an early pulse start. Further patterns cover the following:
- a retrigger inside an active pulse, which must not stretch it;
- several coincidences in one frame, which must give one bit and one count;
- hits on a pixel that is not in row 0, which checks the row and column mapping and that the shadow holds while new hits arrive;
- a mask change around a frame boundary;
- saturation of a narrow counter;
- a clear that coincides with a frame boundary.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  typedef enum logic [1:0] {
    WIN_SHORT = 2'd0,
    WIN_MID   = 2'd1,
    WIN_LONG  = 2'd2,
    WIN_LONG2 = 2'd3
  } win_sel_e;

  // Pulse length in cycles for a window select code
  function automatic int unsigned win_len(input logic [1:0] sel,
                                          input int unsigned s,
                                          input int unsigned m,
                                          input int unsigned l);
    case (win_sel_e'(sel))
      WIN_SHORT: return s;
      WIN_MID:   return m;
      default:   return l;
    endcase
  endfunction
endpackage

// File: rtl/coinc_oneshot.sv
module coinc_oneshot #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [LW-1:0] len,
  output logic          pulse
);
  logic          hit_q;
  logic          act;
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      act   <= 1'b0;
      left  <= '0;
    end else begin
      hit_q <= hit;
      if (act) begin
        if (left == '0) act <= 1'b0;
        else            left <= left - 1'b1;
      end else if (hit && !hit_q) begin
        act  <= 1'b1;
        left <= len - 1'b1;
      end
    end
  end

  assign pulse = act;
endmodule

// File: rtl/coinc_pixel.sv
module coinc_pixel #(
  parameter int LW    = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             top_hit,
  input  logic             bot_hit,
  input  logic [LW-1:0]    len,
  input  logic             en_now,
  input  logic             en_next,
  input  logic             frame_close,
  input  logic             cnt_clear,
  output logic             pulse_t,
  output logic             pulse_b,
  output logic             latch,
  output logic             shadow,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic coinc;

  coinc_oneshot #(.LW(LW)) u_os_top (
    .clk(clk), .rst(rst), .hit(top_hit), .len(len), .pulse(pulse_t));
  coinc_oneshot #(.LW(LW)) u_os_bot (
    .clk(clk), .rst(rst), .hit(bot_hit), .len(len), .pulse(pulse_b));

  // The mask that governs the new frame applies already in its first cycle
  assign coinc = pulse_t & pulse_b & (frame_close ? en_next : en_now);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch  <= 1'b0;
      shadow <= 1'b0;
    end else if (frame_close) begin
      shadow <= latch;
      latch  <= coinc;
    end else begin
      latch  <= latch | coinc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cnt_clear)                              count <= '0;
    else if (frame_close && latch && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/coinc_cfg.sv
module coinc_cfg #(
  parameter int NPIX = 768
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sdi,
  input  logic            shift,
  input  logic            load,
  input  logic            frame_close,
  output logic [NPIX-1:0] en_now,
  output logic [NPIX-1:0] en_next
);
  logic [NPIX-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '1;
      en_next <= '1;
      en_now  <= '1;
    end else begin
      if (shift)       sr      <= {sr[NPIX-2:0], sdi};
      if (load)        en_next <= sr;
      if (frame_close) en_now  <= en_next;
    end
  end
endmodule

// File: rtl/coinc_pixel_array.sv
module coinc_pixel_array #(
  parameter int ROWS     = 16,
  parameter int COLS     = 48,
  parameter int CNT_W    = 16,
  parameter int PW_SHORT = 1,
  parameter int PW_MID   = 2,
  parameter int PW_LONG  = 13
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ROWS*COLS-1:0]            top_hit,
  input  logic [ROWS*COLS-1:0]            bot_hit,
  input  logic [1:0]                      win_sel,
  input  logic                            frame_close,
  input  logic                            cfg_sdi,
  input  logic                            cfg_shift,
  input  logic                            cfg_load,
  input  logic                            cnt_clear,
  input  logic [$clog2(ROWS)-1:0]         rd_row,
  output logic [COLS-1:0]                 rd_bits,
  input  logic [$clog2(ROWS*COLS)-1:0]    cnt_addr,
  output logic [CNT_W-1:0]                cnt_q
);
  import coinc_pkg::*;

  localparam int NPIX = ROWS * COLS;
  localparam int RW   = $clog2(ROWS);
  localparam int AW   = $clog2(NPIX);
  localparam int LW   = $clog2(PW_LONG + 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [AW-1:0] LAST_PIX = AW'(NPIX - 1);

  logic [LW-1:0]    len;
  logic [NPIX-1:0]  en_vec, en_nxt_vec;
  logic [NPIX-1:0]  latch_vec, shadow_vec, pt_vec, pb_vec;
  logic [CNT_W-1:0] cnt_arr [NPIX];

  assign len = LW'(win_len(win_sel, PW_SHORT, PW_MID, PW_LONG));

  coinc_cfg #(.NPIX(NPIX)) u_cfg (
    .clk(clk), .rst(rst), .sdi(cfg_sdi), .shift(cfg_shift), .load(cfg_load),
    .frame_close(frame_close), .en_now(en_vec), .en_next(en_nxt_vec));

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    coinc_pixel #(.LW(LW), .CNT_W(CNT_W)) u_pix (
      .clk(clk), .rst(rst),
      .top_hit(top_hit[p]), .bot_hit(bot_hit[p]), .len(len),
      .en_now(en_vec[p]), .en_next(en_nxt_vec[p]),
      .frame_close(frame_close), .cnt_clear(cnt_clear),
      .pulse_t(pt_vec[p]), .pulse_b(pb_vec[p]),
      .latch(latch_vec[p]), .shadow(shadow_vec[p]), .count(cnt_arr[p]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bits <= '0;
      cnt_q   <= '0;
    end else begin
      rd_bits <= (rd_row <= LAST_ROW) ? shadow_vec[int'(rd_row)*COLS +: COLS] : '0;
      cnt_q   <= (cnt_addr <= LAST_PIX) ? cnt_arr[cnt_addr] : '0;
    end
  end
endmodule

// File: rtl/coinc_pixel_array_chk.sv
module coinc_pixel_array_chk #(
  parameter int NPIX = 768
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_close,
  input logic [NPIX-1:0] en_vec,
  input logic [NPIX-1:0] latch_vec,
  input logic [NPIX-1:0] shadow_vec,
  input logic [NPIX-1:0] pt_vec,
  input logic [NPIX-1:0] pb_vec
);
  p_masked_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (latch_vec & ~en_vec) == '0);

  p_needs_both_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (latch_vec & ~($past(latch_vec) & {NPIX{!$past(frame_close)}})
              & ~($past(pt_vec) & $past(pb_vec))) == '0);

  p_overlap_sets_r1: assert property (@(posedge clk) disable iff (rst)
    !frame_close |=> ($past(pt_vec & pb_vec & en_vec) & ~latch_vec) == '0);

  p_one_bit_r5: assert property (@(posedge clk) disable iff (rst)
    !frame_close |=> ($past(latch_vec) & ~latch_vec) == '0);

  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    frame_close |=> shadow_vec == $past(latch_vec));

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_close |=> $stable(shadow_vec));

  p_mask_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_close |=> $stable(en_vec));
endmodule

bind coinc_pixel_array coinc_pixel_array_chk #(.NPIX(ROWS*COLS)) u_chk (
  .clk(clk), .rst(rst), .frame_close(frame_close), .en_vec(en_vec),
  .latch_vec(latch_vec), .shadow_vec(shadow_vec), .pt_vec(pt_vec), .pb_vec(pb_vec));

// File: tb/test_coinc_pixel_array.sv
`timescale 1ns/1ps
module test_coinc_pixel_array;
  localparam int ROWS = 2, COLS = 3, CNT_W = 3, NPIX = ROWS * COLS;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [NPIX-1:0] top_hit = '0, bot_hit = '0;
  logic [1:0] win_sel = 2'd0;
  logic frame_close = 0, cfg_sdi = 0, cfg_shift = 0, cfg_load = 0, cnt_clear = 0;
  logic [$clog2(ROWS)-1:0] rd_row = '0;
  logic [COLS-1:0] rd_bits;
  logic [$clog2(NPIX)-1:0] cnt_addr = '0;
  logic [CNT_W-1:0] cnt_q;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coinc_pixel_array #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) i_coinc_pixel_array (
    .clk(clk), .rst(rst), .top_hit(top_hit), .bot_hit(bot_hit), .win_sel(win_sel),
    .frame_close(frame_close), .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .cnt_clear(cnt_clear), .rd_row(rd_row), .rd_bits(rd_bits),
    .cnt_addr(cnt_addr), .cnt_q(cnt_q));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic close_frame(input bit clr = 0);
    @(negedge clk); frame_close = 1; cnt_clear = clr;
    @(negedge clk); frame_close = 0; cnt_clear = 0;
  endtask

  task automatic read_row(input int r, output int v);
    rd_row = r[$clog2(ROWS)-1:0];
    @(negedge clk); v = int'(rd_bits);
  endtask

  task automatic read_cnt(input int p, output int v);
    cnt_addr = p[$clog2(NPIX)-1:0];
    @(negedge clk); v = int'(cnt_q);
  endtask

  // Single-cycle hits on both layers of pixel p in the same cycle
  task automatic coinc(input int p);
    @(negedge clk); top_hit[p] = 1; bot_hit[p] = 1;
    @(negedge clk); top_hit[p] = 0; bot_hit[p] = 0;
    idle(16);
  endtask

  initial begin
    int v, nco, wl;
    idle(3); rst = 0;
    read_row(0, v); chk("R10 shadow row0 after reset", v, 0);
    read_row(1, v); chk("R10 shadow row1 after reset", v, 0);
    read_cnt(0, v); chk("R10 count after reset", v, 0);

    // R1/R2 sweep: offset d between upper and lower rising edges on pixel 0
    nco = 0;
    for (int w = 0; w < 3; w++) begin
      win_sel = w[1:0];
      wl = (w == 0) ? 1 : (w == 1) ? 2 : 13;
      for (int d = -14; d <= 14; d++) begin
        for (int k = 0; k < 46; k++) begin
          @(negedge clk);
          top_hit[0] = (k == 15);
          bot_hit[0] = (k == 15 + d);
        end
        close_frame();
        read_row(0, v);
        chk($sformatf("R1 R2 win=%0d offset=%0d", w, d), v, ((d < wl && -d < wl) ? 1 : 0));
        if (d < wl && -d < wl) nco++;
      end
    end
    read_cnt(0, v); chk("R8 saturated count", v, (nco > CMAX) ? CMAX : nco);
    read_cnt(1, v); chk("R8 idle pixel count", v, 0);

    @(negedge clk); cnt_clear = 1; @(negedge clk); cnt_clear = 0;
    read_cnt(0, v); chk("R9 clear count", v, 0);

    // R5: three coincidences in one frame on pixel 1
    win_sel = 2'd1;
    coinc(1); coinc(1); coinc(1);
    close_frame();
    read_row(0, v); chk("R5 one bit", v, 3'b010);
    read_cnt(1, v); chk("R5 one count", v, 1);

    // R2 retrigger ignored: upper rises at 0 and 5, lower at 14, window 13
    win_sel = 2'd3;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      top_hit[0] = (k == 2 || k == 7);
      bot_hit[0] = (k == 16);
    end
    close_frame();
    read_row(0, v); chk("R2 retrigger ignored", v, 0);

    // R3/R6: pixel 4 is row 1 column 1; shadow holds while next frame integrates
    win_sel = 2'd0;
    coinc(4);
    close_frame();
    read_row(1, v); chk("R3 row1 mapping", v, 3'b010);
    coinc(3);
    read_row(1, v); chk("R6 shadow held", v, 3'b010);
    close_frame();
    read_row(1, v); chk("R6 next frame capture", v, 3'b001);
    read_cnt(4, v); chk("R3 count index 4", v, 1);

    // R7: disable pixel 0; bits shifted for pixel 5 down to pixel 0
    for (int p = NPIX - 1; p >= 0; p--) begin
      @(negedge clk); cfg_shift = 1; cfg_sdi = (p != 0);
    end
    @(negedge clk); cfg_shift = 0; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    coinc(0);
    close_frame();
    read_row(0, v); chk("R7 mask waits for boundary", v, 3'b001);
    coinc(0); coinc(2);
    close_frame();
    read_row(0, v); chk("R4 masked pixel silent", v, 3'b100);
    read_cnt(0, v); chk("R4 masked pixel count", v, 1);

    // R9: clear wins over increment at the same boundary
    coinc(2);
    close_frame(1);
    read_row(0, v); chk("R9 capture with clear", v, 3'b100);
    read_cnt(2, v); chk("R9 clear beats increment", v, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule